// File: doc/BRIEF.md
# Software Write-Protection Command Decoder

This block sits beside the page writer of a byte-wide EEPROM. It sees every completed byte-write cycle as an address and a data byte with a one-cycle valid strobe. For each write it returns a registered decision: store the byte, or let the write run its timing and drop the data. The address space is cut into equal blocks, selected by the top address bits. Each block has its own protect bit. Magic address/data sequences, matched on the low 15 address bits, arm writes into protected blocks and set or clear a block's protect bit.

A write window opens with each accepted write and is retriggered by every later one. The window closes after a parameterised number of idle cycles. When it closes, any pending enable or disable command is committed to the protect bit of the block named by the command's final byte. The open unlock state then ends. A supply-good input holds all writes off while the supply is low and for a parameterised number of cycles after it returns. The protect bits load from an input at reset and are exported for saving. A supply drop never changes them.

Top module: `eewp_guard`

## Requirements
- R1: During and after reset, `prot_state` equals `prot_init`, and `dec_valid`, `dec_permit` and `win_busy` are 0. `lock_active` is 1, because the lockout counter starts full.
- R2: `lock_active` is 1 while `supply_ok` is 0 and for LOCK_CYC cycles after it returns to 1. A write seen while `lock_active` is 1 gets `dec_permit` 0, and it does not touch the command tracker or the write window.
- R3: Every write strobe produces `dec_valid` 1 one cycle later. A write to a block whose protect bit is 0, outside lockout, gets `dec_permit` 1 in that same cycle.
- R4: A write outside lockout to a block whose protect bit is 1 gets `dec_permit` 0 unless an unlock sequence is open. The write still restarts the write window.
- R5: The writes AA@5555, 55@2AAA, A0@5555 (hex, low 15 address bits) open unlock. Until the window closes, every accepted write to any block is permitted. The block held in address bits [AW-1:AW-2] of the A0 write gets its protect bit set when the window closes.
- R6: A pending command commits on the clock edge at which the window expires: WIN_CYC cycles after the last accepted write. It commits even if no data write followed the command. `prot_state` changes at no other time.
- R7: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 open unlock. When the window closes, they clear the protect bit of the block held in the last write's upper address bits.
- R8: An accepted write that does not match the next expected step returns the tracker to its start. If that write is itself AA@5555, it counts as the first step, so the next expected write is 55@2AAA.
- R9: When `supply_ok` is 0, any pending command and any partial sequence are discarded, the window is cleared, and `prot_state` keeps its value.
- R10: `win_busy` is 1 from the cycle after an accepted write until WIN_CYC cycles after the most recent accepted write.
- R11: `prot_state` exports the current protect bit of each block: bit i for block i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe for a completed byte write |
| wr_addr | input | AW | Write address; the top log2(NBLK) bits select the block |
| wr_data | input | 8 | Write data byte |
| supply_ok | input | 1 | Supply-good indication |
| prot_init | input | NBLK | Protect bits loaded at reset |
| dec_valid | output | 1 | Decision strobe, one cycle after `wr_valid` |
| dec_permit | output | 1 | 1 = store the byte, 0 = suppress it |
| win_busy | output | 1 | Write window in progress |
| lock_active | output | 1 | Supply lockout in force |
| prot_state | output | NBLK | Current protect bits, for saving |

## Verification
The bench drives plain writes into protected and unprotected blocks. It contrasts the stored and suppressed outcomes, and shows that a suppressed write still restarts the window. Both command sequences are sent with and without trailing data bytes. This separates a commit tied to the window expiring from one tied to data arriving. Broken sequences are sent with a random byte and with a repeated AA@5555, so that a full reset of the tracker can be told apart from a restart at step two. A supply drop in the middle of a pending command shows that it is discarded while the stored protect bits are kept.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] CMD_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] CMD_ADDR_LO = 15'h2AAA;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_ACK   = 8'h55;
  localparam logic [7:0] KEY_SET   = 8'hA0;
  localparam logic [7:0] KEY_EXT   = 8'h80;
  localparam logic [7:0] KEY_CLEAR = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GOT_OPEN,
    SQ_GOT_ACK,
    SQ_EXT,
    SQ_EXT_OPEN,
    SQ_EXT_ACK,
    SQ_ARMED
  } seq_e;

  function automatic logic cmd_is(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                                  input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic seq_e seq_step(input seq_e cur, input logic [CMD_AW-1:0] a,
                                    input logic [7:0] d);
    seq_e fallback;
    fallback = cmd_is(a, d, CMD_ADDR_HI, KEY_OPEN) ? SQ_GOT_OPEN : SQ_IDLE;
    case (cur)
      SQ_IDLE:     return fallback;
      SQ_GOT_OPEN: return cmd_is(a, d, CMD_ADDR_LO, KEY_ACK) ? SQ_GOT_ACK : fallback;
      SQ_GOT_ACK: begin
        if (cmd_is(a, d, CMD_ADDR_HI, KEY_SET)) return SQ_ARMED;
        if (cmd_is(a, d, CMD_ADDR_HI, KEY_EXT)) return SQ_EXT;
        return fallback;
      end
      SQ_EXT:      return cmd_is(a, d, CMD_ADDR_HI, KEY_OPEN) ? SQ_EXT_OPEN : SQ_IDLE;
      SQ_EXT_OPEN: return cmd_is(a, d, CMD_ADDR_LO, KEY_ACK) ? SQ_EXT_ACK : fallback;
      SQ_EXT_ACK:  return cmd_is(a, d, CMD_ADDR_HI, KEY_CLEAR) ? SQ_ARMED : fallback;
      SQ_ARMED:    return SQ_ARMED;
      default:     return SQ_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/eewp_lockout.sv
module eewp_lockout #(
  parameter int LOCK_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic locked
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= LW'(LOCK_CYC);
    else if (!supply_ok)   cnt_q <= LW'(LOCK_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign locked = !supply_ok || (cnt_q != '0);

  a_r2_lock_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> locked);

endmodule

// File: rtl/eewp_window.sv
module eewp_window #(
  parameter int WIN_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic supply_ok,
  output logic busy,
  output logic close
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!supply_ok)  cnt_q <= '0;
    else if (acc)         cnt_q <= WW'(WIN_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy  = (cnt_q != '0);
  assign close = supply_ok && !acc && (cnt_q == WW'(1));

  a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && supply_ok) |=> busy);

endmodule

// File: rtl/eewp_seq_track.sv
module eewp_seq_track #(
  parameter int BW = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc,
  input  logic                        abort,
  input  logic [eewp_pkg::CMD_AW-1:0] addr_lo,
  input  logic [7:0]                  data,
  input  logic [BW-1:0]               blk,
  output logic                        armed,
  output logic                        pend_en,
  output logic                        pend_dis,
  output logic [BW-1:0]               pend_blk
);
  import eewp_pkg::*;

  seq_e st_q, st_d;
  logic hit_set, hit_clear;

  always_comb begin
    st_d      = seq_step(st_q, addr_lo, data);
    hit_set   = acc && (st_q == SQ_GOT_ACK) && (st_d == SQ_ARMED);
    hit_clear = acc && (st_q == SQ_EXT_ACK) && (st_d == SQ_ARMED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st_q     <= SQ_IDLE;
      pend_en  <= 1'b0;
      pend_dis <= 1'b0;
      pend_blk <= '0;
    end else if (acc) begin
      st_q <= st_d;
      if (hit_set || hit_clear) begin
        pend_en  <= hit_set;
        pend_dis <= hit_clear;
        pend_blk <= blk;
      end
    end
  end

  assign armed = (st_q == SQ_ARMED);

  a_r5_arm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(acc));

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!armed && !pend_en && !pend_dis));

endmodule

// File: rtl/eewp_guard.sv
module eewp_guard #(
  parameter int AW       = 17,
  parameter int NBLK     = 4,
  parameter int LOCK_CYC = 500000,
  parameter int WIN_CYC  = 15000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            supply_ok,
  input  logic [NBLK-1:0] prot_init,
  output logic            dec_valid,
  output logic            dec_permit,
  output logic            win_busy,
  output logic            lock_active,
  output logic [NBLK-1:0] prot_state
);
  import eewp_pkg::*;

  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic [NBLK-1:0] prot_q;
  logic [BW-1:0]   wr_blk;
  logic            acc;
  logic            win_close;
  logic            abort;
  logic            armed;
  logic            pend_en, pend_dis;
  logic [BW-1:0]   pend_blk;
  logic            may_store;

  assign wr_blk    = wr_addr[AW-1 -: BW];
  assign acc       = wr_valid && !lock_active;
  assign abort     = !supply_ok || win_close;
  assign may_store = acc && (!prot_q[wr_blk] || armed);

  eewp_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .locked(lock_active)
  );

  eewp_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .acc(acc), .supply_ok(supply_ok),
    .busy(win_busy), .close(win_close)
  );

  eewp_seq_track #(.BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .abort(abort),
    .addr_lo(wr_addr[CMD_AW-1:0]), .data(wr_data), .blk(wr_blk),
    .armed(armed), .pend_en(pend_en), .pend_dis(pend_dis), .pend_blk(pend_blk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_permit <= 1'b0;
    end else begin
      dec_valid  <= wr_valid;
      dec_permit <= may_store;
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_prot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prot_q[g] <= prot_init[g];
      end else if (win_close && (pend_blk == BW'(g))) begin
        if (pend_en)       prot_q[g] <= 1'b1;
        else if (pend_dis) prot_q[g] <= 1'b0;
      end
    end
  end

  assign prot_state = prot_q;

  a_r2_locked_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_active) |=> !dec_permit);

  a_r4_protected_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot_q[wr_blk] && !armed) |=> !dec_permit);

  a_r6_prot_moves_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> $stable(prot_q));

  a_r9_prot_kept_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> $stable(prot_q));

endmodule

// File: tb/tb_eewp_guard.sv
module tb_eewp_guard;
  localparam int AW = 17;
  localparam int NB = 4;
  localparam int LOCK = 40;
  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic supply_ok = 1'b1;
  logic [NB-1:0] prot_init = 4'b0100;
  logic dec_valid, dec_permit, win_busy, lock_active;
  logic [NB-1:0] prot_state;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  eewp_guard #(.AW(AW), .NBLK(NB), .LOCK_CYC(LOCK), .WIN_CYC(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .supply_ok(supply_ok), .prot_init(prot_init),
    .dec_valid(dec_valid), .dec_permit(dec_permit), .win_busy(win_busy),
    .lock_active(lock_active), .prot_state(prot_state)
  );

  // Behavioural reference model: disable-sequence progress counter k.
  int m_lcnt, m_wcnt, m_k, m_pblk;
  bit m_armed, m_pen, m_pdis, m_dv, m_dp;
  bit [NB-1:0] m_prot;
  int seq_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int seq_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lcnt = LOCK; m_wcnt = 0; m_k = 0; m_armed = 0; m_pen = 0; m_pdis = 0;
      m_pblk = 0; m_prot = prot_init; m_dv = 0; m_dp = 0;
    end else begin
      bit locked, acc, close, aa;
      int blk, lo;
      locked = !supply_ok || (m_lcnt != 0);
      acc = wr_valid && !locked;
      blk = int'(wr_addr[16:15]);
      lo = int'(wr_addr[14:0]);
      close = supply_ok && !acc && (m_wcnt == 1);
      m_dv = wr_valid;
      m_dp = acc && (!m_prot[blk] || m_armed);
      if (close && m_pen) m_prot[m_pblk] = 1'b1;
      if (close && m_pdis) m_prot[m_pblk] = 1'b0;
      if (!supply_ok || close) begin
        m_k = 0; m_armed = 0; m_pen = 0; m_pdis = 0;
      end else if (acc && !m_armed) begin
        aa = (lo == 'h5555) && (wr_data == 8'hAA);
        if (m_k == 2 && lo == 'h5555 && wr_data == 8'hA0) begin
          m_armed = 1; m_pen = 1; m_pblk = blk;
        end else if (lo == seq_a[m_k] && int'(wr_data) == seq_d[m_k]) begin
          m_k++;
          if (m_k == 6) begin m_armed = 1; m_pdis = 1; m_pblk = blk; end
        end else begin
          m_k = aa ? 1 : 0;
        end
      end
      if (!supply_ok) m_wcnt = 0;
      else if (acc) m_wcnt = WIN;
      else if (m_wcnt > 0) m_wcnt--;
      if (!supply_ok) m_lcnt = LOCK;
      else if (m_lcnt > 0) m_lcnt--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R3 dec_valid", 32'(dec_valid), 32'(m_dv));
    chk("R4 dec_permit", 32'(dec_permit), 32'(m_dp));
    chk("R10 win_busy", 32'(win_busy), 32'(m_wcnt != 0));
    chk("R2 lock_active", 32'(lock_active), 32'(!supply_ok || m_lcnt != 0));
    chk("R11 prot_state", 32'(prot_state), 32'(m_prot));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 prot_init during reset", 32'(prot_state), 32'h4);
    chk("R1 lock at reset", 32'(lock_active), 32'h1);
    rst_n = 1'b1;
    tick();
    chk("R1 prot after reset", 32'(prot_state), 32'h4);
    chk("R1 idle window", 32'(win_busy), 32'h0);
    // R2: write during power-on lockout
    wr(17'h00010, 8'h11);
    chk("R2 lockout suppress", 32'(dec_permit), 32'h0);
    chk("R2 lockout no window", 32'(win_busy), 32'h0);
    idle(LOCK + 2);
    chk("R2 lockout ended", 32'(lock_active), 32'h0);
    // R3: unprotected block
    wr(17'h00010, 8'h22);
    chk("R3 unprotected permit", 32'(dec_permit), 32'h1);
    idle(WIN + 2);
    // R10: retrigger
    wr(17'h00001, 8'h01);
    idle(15);
    wr(17'h00002, 8'h02);
    idle(10);
    chk("R10 retriggered busy", 32'(win_busy), 32'h1);
    idle(12);
    chk("R10 window done", 32'(win_busy), 32'h0);
    // R4: protected block, no prefix
    wr(17'h10003, 8'h33);
    chk("R4 protected suppress", 32'(dec_permit), 32'h0);
    chk("R4 timer started", 32'(win_busy), 32'h1);
    idle(WIN + 2);
    // R5: enable block1, with a data byte into protected block2
    wr(17'h0D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h0D555, 8'hA0);
    wr(17'h10004, 8'h44);
    chk("R5 armed write permitted", 32'(dec_permit), 32'h1);
    idle(WIN - 1);
    chk("R6 not yet committed", 32'(prot_state), 32'h4);
    tick();
    chk("R5 block1 protected", 32'(prot_state), 32'h6);
    idle(3);
    // R6: enable block0 with no data bytes
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    idle(WIN + 2);
    chk("R6 commit without data", 32'(prot_state), 32'h7);
    // R8: broken sequence
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h00100, 8'h12);
    wr(17'h05555, 8'hA0);
    wr(17'h10020, 8'h55);
    chk("R8 break resets tracker", 32'(dec_permit), 32'h0);
    idle(WIN + 2);
    chk("R8 no commit after break", 32'(prot_state), 32'h7);
    // R8: repeated AA restarts at step two
    wr(17'h1D555, 8'hAA); wr(17'h1D555, 8'hAA); wr(17'h1AAAA, 8'h55);
    wr(17'h1D555, 8'hA0);
    idle(WIN + 2);
    chk("R8 restart at step two", 32'(prot_state), 32'hF);
    // R7: disable block2
    wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h15555, 8'h80);
    wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h15555, 8'h20);
    idle(WIN + 2);
    chk("R7 block2 cleared", 32'(prot_state), 32'hB);
    wr(17'h10009, 8'h99);
    chk("R7 plain write now permitted", 32'(dec_permit), 32'h1);
    idle(WIN + 2);
    // R9: supply drop aborts a pending enable
    wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h15555, 8'hA0);
    idle(3);
    supply_ok = 1'b0;
    idle(5);
    chk("R9 bits kept while low", 32'(prot_state), 32'hB);
    supply_ok = 1'b1;
    idle(LOCK + WIN + 5);
    chk("R9 pending discarded", 32'(prot_state), 32'hB);
    wr(17'h00007, 8'h77);
    chk("R9 block0 still protected", 32'(dec_permit), 32'h0);
    idle(WIN + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule